// File: doc/BRIEF.md
# Attribute Register Port

This block holds the colour and display-attribute settings of a video pipeline behind a small CPU register bus. Twenty-one byte registers sit behind a single write port that alternates between two meanings: a flag inside the block decides whether the next byte written there is taken as a register index or as data for the register already indexed. Reading a separate clear port returns that flag to the index meaning, so software can always start a known sequence. Register contents are read back through a dedicated read-data port.

The index byte does double duty. Its low five bits choose the register, and bit 5 is the display enable for the downstream pixel logic. Writing an index with bit 5 clear blanks the screen, and writing an index with it set brings the display back. All register contents are driven continuously to the pixel logic, together with a four-bit colour page. The colour page comes from the colour-select register and the paging-mode bit of the mode register.

Top module: `attr_regport`

## Requirements
- R1: After reset every register reads 0, the stored index is 0, `video_en` is 0 and the next write to the shared port (select 0) is taken as an index.
- R2: On the shared port, a write in the index state loads the index, and the following write stores its byte into the indexed register. After that data write the block returns to the index state, so index and data writes alternate.
- R3: A read with `bus_sel` = 2 (clear port) returns 0 and forces the index state, so the next shared-port write is an index even when a data write was due.
- R4: Of an index byte, bits 4:0 select the register, bit 5 is the display enable and bits 7:6 are discarded. A read with `bus_sel` = 0 returns {2'b00, enable, index}.
- R5: `video_en` follows bit 5 of the last index written and changes only on an index write. Data writes leave it unchanged.
- R6: Registers 0x00 to 0x0F are palette entries, with entry n on `pal_flat[n*8+7:n*8]`. 0x10 drives `mode_ctl`, 0x11 `overscan`, 0x12 `plane_en`, 0x13 `pix_pan` and 0x14 `color_sel`.
- R7: A read with `bus_sel` = 1 returns the register at the current index in the same cycle as the read strobe, and does not change the index/data state.
- R8: Indices 0x15 to 0x1F hold no register. Data writes to them change nothing, and reads of them return 0.
- R9: `color_page` equals `color_sel[3:0]` when `mode_ctl[7]` is 1. When `mode_ctl[7]` is 0 it equals {`color_sel[1:0]`, 2'b00}.
- R10: Intensity bit 3 of the mode register can be flipped by reading the register and writing back the value with only bit 3 changed. The other seven bits are left as they were.
- R11: Writes with `bus_sel` 1, 2 or 3 change no register, no index and not the index/data state.
- R12: `bus_rdata` is 0 in any cycle without `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 2 | Port select: 0 shared index/data, 1 read data, 2 clear, 3 spare |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid while `bus_rd` is high |
| pal_flat | output | 128 | Sixteen palette entries, entry n at bits n*8+7:n*8 |
| mode_ctl | output | 8 | Mode register |
| overscan | output | 8 | Border colour register |
| plane_en | output | 8 | Plane enable register |
| pix_pan | output | 8 | Pixel panning register |
| color_sel | output | 8 | Colour-select register |
| color_page | output | 4 | Colour page formed from mode and colour select |
| video_en | output | 1 | Display enable taken from index bit 5 |

## Verification
A wrong index/data flag is the most damaging fault in this block. Every later write changes meaning: a data byte lands in the index, or an index lands in a register. The fault shows on the next write, either in the index read-back or on a register output one cycle later. A wrong stored index shows at once in the index read or the read-data port, and it shows in `video_en` if bit 5 is affected. A corrupted register or page decode is visible on the output bus continuously, so the sweeps compare every output after each write.

// File: rtl/attr_pkg.sv
package attr_pkg;
  // Port select encoding on the CPU bus
  typedef enum logic [1:0] {
    SEL_SHARED = 2'd0,
    SEL_RDATA  = 2'd1,
    SEL_FFCLR  = 2'd2,
    SEL_SPARE  = 2'd3
  } port_sel_e;

  localparam int IDX_W   = 5;            // register select bits of an index byte
  localparam int VID_BIT = 5;            // display enable position in the index byte
  localparam int IXQ_W   = IDX_W + 1;    // stored index plus enable

  // Non-palette register numbers; downstream logic decodes these positions
  localparam int IX_MODE  = 16;
  localparam int IX_OVSC  = 17;
  localparam int IX_PLANE = 18;
  localparam int IX_PAN   = 19;
  localparam int IX_CSEL  = 20;
endpackage

// File: rtl/attr_rst_sync.sv
module attr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign srst_n = s1_q;
endmodule

// File: rtl/attr_phase_ctl.sv
module attr_phase_ctl
  import attr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_shared,
  input  logic             clr_ff,
  input  logic [DW-1:0]    wdata,
  output logic             data_phase,
  output logic             data_we,
  output logic [IDX_W-1:0] idx,
  output logic             vid_en
);
  logic             ph_q, ph_d;
  logic [IXQ_W-1:0] idx_q, idx_d;
  logic             idx_en;

  // next state: an index-state write loads the index; every write flips the
  // state; a clear-port read forces the index state after this cycle
  always_comb begin
    idx_en = wr_shared && !ph_q;
    idx_d  = idx_q;
    if (idx_en) idx_d = wdata[IXQ_W-1:0];
    ph_d = ph_q;
    if (clr_ff)         ph_d = 1'b0;
    else if (wr_shared) ph_d = !ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      idx_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign data_phase = ph_q;
  assign data_we    = wr_shared && ph_q;
  assign idx        = idx_q[IDX_W-1:0];
  assign vid_en     = idx_q[VID_BIT];

  // R3
  ff_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ff |=> !data_phase);

  // R2
  ff_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_shared && !clr_ff) |=> (data_phase != $past(data_phase)));

  // R4
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_shared && !data_phase) |=> (idx == $past(wdata[IDX_W-1:0])));

  // R5
  vid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_shared && !data_phase) |=> $stable(vid_en));
endmodule

// File: rtl/attr_reg_bank.sv
module attr_reg_bank
  import attr_pkg::*;
#(
  parameter int DW       = 8,
  parameter int NUM_REGS = 21
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IDX_W-1:0]       widx,
  input  logic [DW-1:0]          wdata,
  input  logic [IDX_W-1:0]       ridx,
  output logic [DW-1:0]          rdata,
  output logic [NUM_REGS*DW-1:0] regs_flat
);
  localparam logic [IDX_W-1:0] LAST_IX = IDX_W'(NUM_REGS - 1);

  logic [NUM_REGS-1:0] we_vec;

  always_comb begin
    for (int r = 0; r < NUM_REGS; r++)
      we_vec[r] = we && (widx == IDX_W'(r));
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (we_vec[g]) q <= wdata;
    end
    assign regs_flat[g*DW +: DW] = q;
  end

  // unimplemented indices fall through to zero
  always_comb begin
    rdata = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (ridx == IDX_W'(r)) rdata = regs_flat[r*DW +: DW];
  end

  // R8
  unimpl_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (widx > LAST_IX)) |=> $stable(regs_flat));

  // R8
  unimpl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ridx > LAST_IX) |-> (rdata == '0));
endmodule

// File: rtl/attr_page_fmt.sv
module attr_page_fmt #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] mode_ctl,
  input  logic [DW-1:0] color_sel,
  output logic [3:0]    color_page
);
  // paging bit set: page taken whole; clear: page counts in steps of four
  always_comb begin
    if (mode_ctl[7]) color_page = color_sel[3:0];
    else             color_page = {color_sel[1:0], 2'b00};
  end

  // R9
  always_comb begin
    if (!mode_ctl[7]) begin
      page_step_chk: assert (color_page[3:2] == color_sel[1:0] && color_page[1:0] == 2'b00);
    end
  end
endmodule

// File: rtl/attr_regport.sv
module attr_regport
  import attr_pkg::*;
#(
  parameter int DW       = 8,
  parameter int NUM_PAL  = 16,
  parameter int NUM_REGS = 21
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            bus_sel,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  output logic [NUM_PAL*DW-1:0] pal_flat,
  output logic [DW-1:0]         mode_ctl,
  output logic [DW-1:0]         overscan,
  output logic [DW-1:0]         plane_en,
  output logic [DW-1:0]         pix_pan,
  output logic [DW-1:0]         color_sel,
  output logic [3:0]            color_page,
  output logic                  video_en
);
  localparam int PAD_W = DW - IXQ_W;

  port_sel_e             sel_e;
  logic                  srst_n;
  logic                  wr_shared, clr_ff;
  logic                  data_phase, data_we;
  logic [IDX_W-1:0]      idx;
  logic                  vid;
  logic [DW-1:0]         bank_rdata;
  logic [NUM_REGS*DW-1:0] regs_flat;

  assign sel_e = port_sel_e'(bus_sel);

  attr_rst_sync i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // strobe decode
  assign wr_shared = bus_wr && (sel_e == SEL_SHARED);
  assign clr_ff    = bus_rd && (sel_e == SEL_FFCLR);

  attr_phase_ctl #(.DW(DW)) i_phase (
    .clk        (clk),
    .rst_n      (srst_n),
    .wr_shared  (wr_shared),
    .clr_ff     (clr_ff),
    .wdata      (bus_wdata),
    .data_phase (data_phase),
    .data_we    (data_we),
    .idx        (idx),
    .vid_en     (vid)
  );

  attr_reg_bank #(.DW(DW), .NUM_REGS(NUM_REGS)) i_bank (
    .clk       (clk),
    .rst_n     (srst_n),
    .we        (data_we),
    .widx      (idx),
    .wdata     (bus_wdata),
    .ridx      (idx),
    .rdata     (bank_rdata),
    .regs_flat (regs_flat)
  );

  // read mux, zero outside a read strobe
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (sel_e)
        SEL_SHARED: bus_rdata = {{PAD_W{1'b0}}, vid, idx};
        SEL_RDATA:  bus_rdata = bank_rdata;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign pal_flat  = regs_flat[NUM_PAL*DW-1:0];
  assign mode_ctl  = regs_flat[IX_MODE*DW  +: DW];
  assign overscan  = regs_flat[IX_OVSC*DW  +: DW];
  assign plane_en  = regs_flat[IX_PLANE*DW +: DW];
  assign pix_pan   = regs_flat[IX_PAN*DW   +: DW];
  assign color_sel = regs_flat[IX_CSEL*DW  +: DW];
  assign video_en  = vid;

  attr_page_fmt #(.DW(DW)) i_page (
    .mode_ctl   (mode_ctl),
    .color_sel  (color_sel),
    .color_page (color_page)
  );

  // R7
  rd_keeps_phase_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_rd && sel_e == SEL_RDATA && !bus_wr) |=> $stable(data_phase));

  // R11
  spare_wr_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_wr && sel_e != SEL_SHARED && !bus_rd) |=>
      ($stable(regs_flat) && $stable(idx) && $stable(vid) && $stable(data_phase)));

  // R12
  always_comb begin
    if (!bus_rd) begin
      rdata_idle_chk: assert (bus_rdata == '0);
    end
  end
endmodule

// File: tb/test_attr_regport.sv
`timescale 1ns/1ps
module test_attr_regport;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   bus_sel;
  logic         bus_wr, bus_rd;
  logic [7:0]   bus_wdata;
  logic [7:0]   bus_rdata;
  logic [127:0] pal_flat;
  logic [7:0]   mode_ctl, overscan, plane_en, pix_pan, color_sel;
  logic [3:0]   color_page;
  logic         video_en;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  attr_regport i_attr_regport (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pal_flat(pal_flat),
    .mode_ctl(mode_ctl), .overscan(overscan), .plane_en(plane_en), .pix_pan(pix_pan),
    .color_sel(color_sel), .color_page(color_page), .video_en(video_en)
  );

  task automatic chk(input string req, input string what, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    bus_sel = s; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [7:0] pattern(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_cleared(input string tag);
    logic [7:0] v;
    chk("R1", {tag, " pal"}, pal_flat, 0);
    chk("R1", {tag, " mode"}, mode_ctl, 0);
    chk("R1", {tag, " overscan"}, overscan, 0);
    chk("R1", {tag, " plane/pan/csel"}, {plane_en, pix_pan, color_sel}, 0);
    chk("R1", {tag, " video_en"}, video_en, 0);
    rd(2'd0, v);
    chk("R1", {tag, " index"}, v, 0);
    // first shared write after reset must be an index
    wr(2'd0, 8'h2A);
    rd(2'd0, v);
    chk("R1", {tag, " first write is index"}, v, 8'h2A);
    chk("R1", {tag, " no data stored"}, pal_flat, 0);
    rd(2'd2, v);
  endtask

  initial begin
    logic [7:0] v, exp;
    logic [127:0] pal_snap;
    bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
    do_reset();

    // R1 reset state
    check_cleared("reset");
    chk("R12", "rdata idle", bus_rdata, 0);

    // R2 R4 R5: write every index then its data byte
    for (int i = 0; i < 32; i++) begin
      wr(2'd0, 8'(8'h20 | i));
      chk("R5", "video_en on index write", video_en, 1);
      rd(2'd0, v);
      chk("R4", "index readback", v, 8'(8'h20 | i));
      wr(2'd0, pattern(i));
      chk("R5", "video_en kept over data write", video_en, 1);
    end

    // R6 output mapping
    for (int n = 0; n < 16; n++) chk("R6", "palette entry", pal_flat[n*8 +: 8], pattern(n));
    chk("R6", "mode_ctl",  mode_ctl,  pattern(16));
    chk("R6", "overscan",  overscan,  pattern(17));
    chk("R6", "plane_en",  plane_en,  pattern(18));
    chk("R6", "pix_pan",   pix_pan,   pattern(19));
    chk("R6", "color_sel", color_sel, pattern(20));

    // R7 R8: read back every index
    for (int i = 0; i < 32; i++) begin
      wr(2'd0, 8'(8'h20 | i));
      rd(2'd1, v);
      exp = (i < 21) ? pattern(i) : 8'h00;
      chk(i < 21 ? "R7" : "R8", "data port read", v, exp);
      rd(2'd2, v);
      chk("R3", "clear port reads 0", v, 0);
    end

    // R4: bits 7:6 of the index byte dropped
    wr(2'd0, 8'hE3);
    rd(2'd0, v);
    chk("R4", "upper index bits dropped", v, 8'h23);
    wr(2'd0, 8'h5A);
    chk("R2", "data after index", pal_flat[3*8 +: 8], 8'h5A);

    // R3: clear port forces index state mid-pair
    wr(2'd0, 8'h31);
    rd(2'd2, v);
    wr(2'd0, 8'h34);
    rd(2'd0, v);
    chk("R3", "write after clear is index", v, 8'h34);
    chk("R3", "overscan untouched", overscan, pattern(17));
    wr(2'd0, 8'h0B);
    chk("R3", "data after clear+index", color_sel, 8'h0B);

    // R7: data-port reads keep the data state
    wr(2'd0, 8'h30);
    rd(2'd1, v);
    rd(2'd1, v);
    wr(2'd0, 8'h81);
    chk("R7", "data state survives reads", mode_ctl, 8'h81);

    // R10: intensity bit read-modify-write
    wr(2'd0, 8'h30); wr(2'd0, 8'hF7);
    wr(2'd0, 8'h30); rd(2'd1, v);
    chk("R10", "mode readback", v, 8'hF7);
    wr(2'd0, v | 8'h08);
    chk("R10", "bit3 set, rest kept", mode_ctl, 8'hFF);
    wr(2'd0, 8'h30); rd(2'd1, v);
    wr(2'd0, v & 8'hF7);
    chk("R10", "bit3 cleared, rest kept", mode_ctl, 8'hF7);

    // R5: blanking index
    wr(2'd0, 8'h05);
    chk("R5", "index bit5 clear blanks", video_en, 0);
    wr(2'd0, 8'h3C);
    chk("R5", "data write keeps blank", video_en, 0);
    chk("R2", "data to entry 5", pal_flat[5*8 +: 8], 8'h3C);
    wr(2'd0, 8'h20);
    chk("R5", "index 0x20 re-enables", video_en, 1);

    // R11: writes to other selects do nothing (block now expects data for 0x00)
    pal_snap = pal_flat;
    wr(2'd1, 8'hAA); wr(2'd2, 8'hAA); wr(2'd3, 8'hAA);
    chk("R11", "palette unchanged", pal_flat, pal_snap);
    rd(2'd0, v);
    chk("R11", "index unchanged", v, 8'h20);
    wr(2'd0, 8'h99);
    chk("R11", "data state kept", pal_flat[7:0], 8'h99);

    // R9: colour page sweep
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 16; c++) begin
        wr(2'd0, 8'h30); wr(2'd0, (m == 1) ? 8'h80 : 8'h00);
        wr(2'd0, 8'h34); wr(2'd0, 8'(8'hF0 | c));
        exp = (m == 1) ? 8'(c) : 8'((c << 2) & 15);
        chk("R9", "color_page", color_page, exp[3:0]);
      end
    end

    // R1: reset again after activity
    do_reset();
    check_cleared("second reset");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule